// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps a short run of upcoming instruction bytes ready for a decoder. It reads the code stream ahead of use as aligned 16-bit words and places the bytes into a six-entry byte queue. The decoder sees the oldest byte, a valid flag and a pop strobe, and may take one byte per clock.

A fetch address is the 24-bit sum of a code-segment base and a 16-bit offset. The offset advances by two after each word and wraps inside the segment. After a jump or an interrupt the surrounding logic pulses `flush` with the new offset. The queue then empties and fetching restarts at the target. If the target is odd, the word containing it is read and only its upper byte is kept. A word request that is still in flight when the flush arrives is allowed to finish, but its data is thrown away.

The memory side is a plain request/acknowledge port. One request is outstanding at a time. The port returns a single word on the cycle it acknowledges a request.

Top module: `insn_prefetch`

## Requirements
- R1: An asynchronous active-low reset leaves the queue empty (`dec_valid` low) and `mem_req` low. Fetching then starts by itself at offset 0000h of the current segment base.
- R2: A new request is raised only when the queue holds at most DEPTH-2 bytes (at least two free slots). At most one request is outstanding. With the queue full and no pops, `mem_req` stays low.
- R3: `mem_addr` equals `cs_base` plus an even 16-bit offset, computed modulo 2^24. The caller keeps `cs_base[0]` at zero, so `mem_addr[0]` is 0.
- R4: Once raised, `mem_req` and `mem_addr` hold steady until the cycle in which `mem_ack` is high. `mem_rdata` is taken in that cycle, and the request drops on the following clock.
- R5: Within a word, the byte at the even address (`mem_rdata[7:0]`) is delivered before the byte at the odd address (`mem_rdata[15:8]`). Bytes reach the decoder in increasing address order, and `dec_byte` shows the oldest byte whenever `dec_valid` is high.
- R6: `flush` empties the queue, so `dec_valid` is low after that clock. It overrides a pop or an acknowledge in the same cycle, and fetching restarts at `flush_ip`.
- R7: When `flush_ip` is odd, the first fetch reads the word at `flush_ip` with bit 0 cleared, and only its upper byte is enqueued. The first byte delivered is therefore the one at the target address.
- R8: Data acknowledged for a request that was issued before a flush is dropped and never reaches the decoder.
- R9: A pop and an enqueue in the same clock both take effect. The byte count never exceeds DEPTH, and no byte is lost or repeated.
- R10: A pop while the queue is empty has no effect. The next byte delivered is still the first byte of the stream.
- R11: The fetch offset wraps from FFFFh to 0000h without carrying into the segment base, so the byte after base+FFFFh is the byte at base+0000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_base | input | 24 | Code-segment base address (bit 0 kept zero) |
| flush | input | 1 | Discard queued bytes and restart at `flush_ip` |
| flush_ip | input | 16 | New instruction-pointer offset for a flush |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | 24 | Even physical address of the requested word |
| mem_ack | input | 1 | Request accepted; `mem_rdata` valid this cycle |
| mem_rdata | input | 16 | Returned word, low byte at the even address |
| dec_valid | output | 1 | Queue holds at least one byte |
| dec_byte | output | 8 | Oldest queued byte |
| dec_pop | input | 1 | Decoder consumes the oldest byte |

## Verification
Every result is one register stage away from its cause. A flush sampled at an edge empties the queue by the next falling edge. The first request after a flush appears one clock after the flush is released. Acknowledged bytes are visible one clock after the acknowledge. A pop removes the head byte at the edge that samples it. The bench drives all inputs and samples all outputs on falling edges only, so each check reads a value that settled a half period after the edge that produced it. The memory model also answers on a falling edge, after a latency the bench can choose, which puts stale returns after a flush into a known cycle.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // Number of bytes a single accepted word contributes to the queue.
  typedef enum logic [1:0] {
    PUSH_NONE = 2'd0,
    PUSH_HI   = 2'd1,
    PUSH_WORD = 2'd2
  } push_e;

endpackage

// File: rtl/pfq_agen.sv
module pfq_agen #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);

  localparam int PAD_W = ADDR_W - OFF_W;

  // Zero-extend the offset so it cannot carry into the segment in 16 bits,
  // while the 24-bit sum wraps naturally.
  assign addr = base + {{PAD_W{1'b0}}, off};

endmodule

// File: rtl/pfq_byteq.sv
module pfq_byteq
  import pfq_pkg::*;
#(
  parameter  int DEPTH = 6,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  push_e         push,
  input  logic [15:0]   wdata,
  input  logic          pop,
  output logic [7:0]    head,
  output logic          valid,
  output logic [CW-1:0] level
);

  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] DEPTH_V = (PW + 1)'(DEPTH);

  logic [PW-1:0] rd_q, rd_n, wr_q, wr_n, wr_p1;
  logic [CW-1:0] lvl_q, lvl_n;
  logic [7:0]    mem_q [DEPTH];
  logic [1:0]    n_in;
  logic          take;
  logic [7:0]    lo_byte;
  logic [DEPTH-1:0] we_lo, we_hi;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p,
                                             input logic [1:0] k);
    logic [PW:0] s;
    s = {1'b0, p} + {{(PW - 1){1'b0}}, k};
    if (s >= DEPTH_V) s = s - DEPTH_V;
    return s[PW-1:0];
  endfunction

  always_comb begin
    case (push)
      PUSH_WORD: n_in = 2'd2;
      PUSH_HI:   n_in = 2'd1;
      default:   n_in = 2'd0;
    endcase
  end

  assign take    = pop && (lvl_q != '0);
  assign wr_p1   = wrap_add(wr_q, 2'd1);
  assign lo_byte = (push == PUSH_HI) ? wdata[15:8] : wdata[7:0];

  // Next-state for pointers and fill level.
  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    lvl_n = lvl_q;
    if (clr) begin
      rd_n  = '0;
      wr_n  = '0;
      lvl_n = '0;
    end else begin
      if (take) rd_n = wrap_add(rd_q, 2'd1);
      wr_n  = wrap_add(wr_q, n_in);
      lvl_n = lvl_q + CW'(n_in) - CW'(take);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      lvl_q <= lvl_n;
    end
  end

  // Per-slot write enables: first byte lands at wr_q, second at wr_q+1.
  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign we_lo[i] = !clr && (push != PUSH_NONE) && (wr_q == PW'(i));
    assign we_hi[i] = !clr && (push == PUSH_WORD) && (wr_p1 == PW'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_lo[i])      mem_q[i] <= lo_byte;
      else if (we_hi[i]) mem_q[i] <= wdata[15:8];
    end
  end

  assign head  = mem_q[rd_q];
  assign valid = (lvl_q != '0);
  assign level = lvl_q;

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16,
  parameter int DEPTH  = 6,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cs_base,
  input  logic              flush,
  input  logic [OFF_W-1:0]  flush_ip,
  input  logic [CW-1:0]     level,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output push_e             push,
  output logic              clr
);

  localparam logic [CW-1:0]    ROOM_V = CW'(DEPTH - 2);
  localparam logic [OFF_W-1:0] STEP   = OFF_W'(2);

  logic [OFF_W-1:0]  off_q, off_n;
  logic              skip_q, skip_n;
  logic              req_q, req_n;
  logic              stale_q, stale_n;
  logic [ADDR_W-1:0] addr_q, addr_calc;
  logic              accept, room, issue;
  logic              off_en, addr_en;

  pfq_agen #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W)
  ) u_agen (
    .base(cs_base),
    .off (off_q),
    .addr(addr_calc)
  );

  assign accept = req_q && mem_ack;
  assign room   = (level <= ROOM_V);
  assign issue  = !flush && !req_q && room;

  always_comb begin
    off_n   = off_q;
    skip_n  = skip_q;
    req_n   = req_q;
    stale_n = stale_q;
    push    = PUSH_NONE;
    clr     = flush;
    off_en  = 1'b0;
    addr_en = 1'b0;
    if (flush) begin
      off_n   = {flush_ip[OFF_W-1:1], 1'b0};
      skip_n  = flush_ip[0];
      off_en  = 1'b1;
      // A request in flight stays on the port until accepted, but is marked.
      req_n   = req_q && !mem_ack;
      stale_n = req_q && !mem_ack;
    end else begin
      if (accept) begin
        req_n   = 1'b0;
        stale_n = 1'b0;
        if (!stale_q) begin
          push   = skip_q ? PUSH_HI : PUSH_WORD;
          off_n  = off_q + STEP;
          skip_n = 1'b0;
          off_en = 1'b1;
        end
      end
      if (issue) begin
        req_n   = 1'b1;
        addr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      skip_q  <= 1'b0;
      req_q   <= 1'b0;
      stale_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      req_q   <= req_n;
      stale_q <= stale_n;
      if (off_en) begin
        off_q  <= off_n;
        skip_q <= skip_n;
      end
      if (addr_en) addr_q <= addr_calc;
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;

endmodule

// File: rtl/insn_prefetch.sv
module insn_prefetch
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16,
  parameter int DEPTH  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cs_base,
  input  logic              flush,
  input  logic [OFF_W-1:0]  flush_ip,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic              dec_valid,
  output logic [7:0]        dec_byte,
  input  logic              dec_pop
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] q_level;
  push_e            q_push;
  logic             q_clr;

  pfq_fetch #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .DEPTH (DEPTH),
    .CW    (LVL_W)
  ) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_base (cs_base),
    .flush   (flush),
    .flush_ip(flush_ip),
    .level   (q_level),
    .mem_ack (mem_ack),
    .mem_req (mem_req),
    .mem_addr(mem_addr),
    .push    (q_push),
    .clr     (q_clr)
  );

  pfq_byteq #(
    .DEPTH(DEPTH)
  ) u_queue (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (q_clr),
    .push (q_push),
    .wdata(mem_rdata),
    .pop  (dec_pop),
    .head (dec_byte),
    .valid(dec_valid),
    .level(q_level)
  );

endmodule

// File: rtl/pfq_chk.sv
module pfq_chk #(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 24,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [ADDR_W-1:0] cs_base,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              dec_valid,
  input logic              dec_pop,
  input logic [LVL_W-1:0]  q_level
);

  localparam logic [LVL_W-1:0] FULL_V = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] ROOM_V = LVL_W'(DEPTH - 2);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!mem_req && !dec_valid));

  p_req_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> ($past(q_level) <= ROOM_V));

  p_even_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !cs_base[0]) |-> !mem_addr[0]);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !dec_valid);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= FULL_V);

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_level == '0 && dec_pop && !mem_ack) |=> (q_level == '0));

endmodule

bind insn_prefetch pfq_chk #(
  .DEPTH (DEPTH),
  .ADDR_W(ADDR_W),
  .LVL_W (LVL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .cs_base  (cs_base),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .dec_valid(dec_valid),
  .dec_pop  (dec_pop),
  .q_level  (q_level)
);

// File: tb/test_insn_prefetch.sv
`timescale 1ns/1ps
module test_insn_prefetch;

  localparam logic [23:0] CS_BASE = 24'h3A5F00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] cs_base;
  logic        flush;
  logic [15:0] flush_ip;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic        dec_valid;
  logic [7:0]  dec_byte;
  logic        dec_pop;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string cur_tag = "R5";
  logic [7:0] obs_byte;
  event got_ev;
  int lat = 0;
  int wcnt = 0;
  logic [23:0] a0;
  bit done = 0;

  always #2 clk = ~clk;

  insn_prefetch i_insn_prefetch (
    .clk(clk), .rst_n(rst_n), .cs_base(cs_base), .flush(flush),
    .flush_ip(flush_ip), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dec_valid(dec_valid),
    .dec_byte(dec_byte), .dec_pop(dec_pop)
  );

  function automatic logic [7:0] fb(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ (a[23:16] + 8'h3C);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: answers on falling edges after 'lat' waiting cycles.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wcnt    = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt    = 0;
    end else if (mem_req) begin
      if (wcnt == 0) a0 = mem_addr;
      if (wcnt >= lat) begin
        chk("R4 address held until ack", {8'h0, mem_addr}, {8'h0, a0});
        chk("R3 even fetch address", {31'h0, mem_addr[0]}, 32'h0);
        mem_ack   = 1'b1;
        mem_rdata = {fb(mem_addr + 24'd1), fb(mem_addr)};
      end else begin
        wcnt++;
      end
    end
  end

  // Monitor: compares each consumed byte with the scoreboard head.
  always @(got_ev) begin : mon
    logic [7:0] e;
    if (exp_q.size() == 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL %s: actual=%h expected=none", cur_tag, obs_byte);
    end else begin
      e = exp_q.pop_front();
      chk(cur_tag, {24'h0, obs_byte}, {24'h0, e});
    end
  end

  task automatic expect_seq(input logic [15:0] t, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(fb(CS_BASE + {8'h0, t + 16'(i)}));
  endtask

  task automatic redirect(input logic [15:0] t, input int n, input string tag);
    @(negedge clk);
    flush    = 1'b1;
    flush_ip = t;
    exp_q.delete();
    expect_seq(t, n);
    cur_tag = tag;
    @(negedge clk);
    flush = 1'b0;
    chk({tag, " / R6 queue empty after flush"}, {31'h0, dec_valid}, 32'h0);
  endtask

  task automatic consume(input int n);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      if (dec_valid) begin
        obs_byte = dec_byte;
        ->got_ev;
        dec_pop = 1'b1;
        got++;
      end else begin
        dec_pop = 1'b0;
      end
    end
    @(negedge clk);
    dec_pop = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    cs_base  = CS_BASE;
    flush    = 1'b0;
    flush_ip = 16'h0;
    dec_pop  = 1'b0;
    mem_rdata = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 dec_valid low in reset", {31'h0, dec_valid}, 32'h0);
    chk("R1 mem_req low in reset", {31'h0, mem_req}, 32'h0);
    rst_n = 1'b1;

    // R1 / R5 / R9: stream from offset 0 after reset, back-to-back pops.
    cur_tag = "R1 R5 R9 sequential stream from reset";
    expect_seq(16'h0000, 14);
    consume(14);

    // R2: fill without popping; no request once full.
    redirect(16'h0200, 12, "R2 R9 fill then drain");
    repeat (30) @(negedge clk);
    chk("R2 no request with full queue", {31'h0, mem_req}, 32'h0);
    chk("R2 bytes held while full", {31'h0, dec_valid}, 32'h1);
    consume(12);

    // R7: odd target, slow memory.
    lat = 2;
    redirect(16'h0103, 7, "R7 odd target");
    consume(7);

    // R8: flush while a request is in flight.
    lat = 6;
    redirect(16'h0400, 0, "R8 first target");
    repeat (2) @(negedge clk);
    chk("R8 request pending at flush", {31'h0, mem_req}, 32'h1);
    redirect(16'h0811, 6, "R8 stale data dropped");
    consume(6);

    // R10: pops while empty are ignored.
    lat = 1;
    redirect(16'h0600, 4, "R10 pops on empty queue ignored");
    dec_pop = 1'b1;
    @(negedge clk);
    chk("R10 empty during early pop", {31'h0, dec_valid}, 32'h0);
    @(negedge clk);
    chk("R10 empty during second pop", {31'h0, dec_valid}, 32'h0);
    dec_pop = 1'b0;
    consume(4);

    // R11: offset wraps inside the segment.
    lat = 0;
    redirect(16'hFFFC, 10, "R11 offset wrap");
    consume(10);

    chk("R5 scoreboard drained", exp_q.size(), 0);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule